// File: doc/BRIEF.md
# DRAM Bank Sequencer with Hidden Refresh and Nybble Burst

This block sequences one bank of page-less DRAM behind a 32-bit synchronous CPU bus. It watches the CPU address strobe, decides whether the access falls in the RAM window, and produces the row strobe, the row/column address select, four per-byte column strobes, the write enable and a synchronous termination strobe back to the CPU. A 32-bit read that arrives with the burst request asserted keeps the row open and streams nybble-mode beats. The block toggles the termination strobe and the column strobes until the CPU withdraws the burst request.

A separate timer pulses a refresh request. The block latches it and runs a refresh between CPU cycles. During the refresh it raises a refresh-enable that switches the external address mux to the refresh counter. A fixed precharge lockout follows each refresh. RAM cycles are held off from the request until the precharge has ended. All timing is expressed in half bus clocks: the block runs on a clock at twice the bus rate. An internal phase bit starts on a rising bus edge after reset and alternates rising and falling bus edges on each tick. A phase code reports what the sequencer is doing.

Top module: `dram_seq`

## Requirements
- R1: An access starts only when addr[31:24] equals 8'h01. A strobe at any other address leaves ras_n high, cas_n at 4'hF and the phase code at 0.
- R2: When the strobe is low on a rising bus edge with a RAM address and no refresh pending, ras_n falls at that edge. col_sel rises one tick later. cas_n and sterm_n assert one tick after col_sel.
- R3: In a normal cycle ras_n returns high two ticks after cas_n asserts. we_n is low exactly while ras_n is low in a write (rw=0) and stays high for a read (rw=1).
- R4: After the strobe goes high, the next tick releases cas_n to 4'hF, sterm_n to 1, col_sel to 0 and the phase code to 0.
- R5: A read asserts all four cas_n bits. A write asserts cas_n[i] for byte offsets i from addr[1:0] up to addr[1:0]+n-1 (capped at 3). Here n is siz (1, 2, 3) or 4 when siz is 2'b00.
- R6: A latched refresh request starts from idle on a falling bus edge if the strobe is high, or if the strobe is low for a RAM cycle being held off. ref_en rises at that edge, ras_n falls one tick later, and cas_n stays at 4'hF throughout.
- R7: During refresh ras_n stays low for two ticks, and ras_n and ref_en then return high together. ras_n stays high for at least four ticks of precharge before it may fall again.
- R8: While a refresh is pending, in progress or precharging, no RAM access starts. A RAM cycle held off this way starts on the first rising bus edge after the precharge ends.
- R9: A read whose burst_n is low on the starting edge is a burst, and ras_n stays low for as long as the phase code is 4. With burst_n low on a write, the cycle is a normal cycle.
- R10: In a burst sterm_n toggles at every falling bus edge. Every cas_n bit equals the value sterm_n had one tick earlier.
- R11: With burst_n high on a falling bus edge of a burst, sterm_n asserts. On the next rising edge ras_n rises and all cas_n bits assert, and the cycle then ends as in R4.
- R12: The phase code is 0 idle, 1 refresh, 2 precharge, 3 access and 4 burst, and never exceeds 4.
- R13: In reset ras_n, we_n and sterm_n are high, cas_n is 4'hF, col_sel and ref_en are low and the phase code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rst_n | input | 1 | Active-low synchronous reset |
| as_n | input | 1 | CPU address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 32 | CPU address |
| siz | input | 2 | Transfer size in bytes, 2'b00 = four |
| burst_n | input | 1 | Burst request, active low |
| rfq | input | 1 | Refresh request pulse from the timer |
| ras_n | output | 1 | Row strobe, active low |
| col_sel | output | 1 | 1 = column address on the mux |
| cas_n | output | 4 | Column strobe per byte offset, active low |
| we_n | output | 1 | Write enable, active low |
| ref_en | output | 1 | Selects the refresh address in the mux |
| sterm_n | output | 1 | Synchronous termination to the CPU, active low |
| phase | output | 3 | Sequencer phase code |

## Verification
The assertions assume a well-behaved CPU. The strobe and the burst request change only between ticks, and a strobe stays low until termination has been seen. A burst request comes only on reads that start on a rising bus edge, and refresh requests arrive as single-tick pulses while no earlier request is still open. The bench meets these assumptions by aligning each cycle to a rising bus edge from its own tick count. It holds the strobe low until after the row strobe has been released, and it pulses the refresh request only from idle. Random addresses, sizes and directions are drawn within those rules.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RF_WAIT,
        S_RF_RAS,
        S_PRE,
        S_ROW,
        S_COL,
        S_CAS,
        S_HOLD,
        S_BURST,
        S_BEND
    } seq_st_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_REF   = 3'd1,
        PH_PRE   = 3'd2,
        PH_ACC   = 3'd3,
        PH_BURST = 3'd4
    } seq_ph_e;

endpackage

// File: rtl/dram_win_dec.sv
module dram_win_dec #(
    parameter int              DEC_W   = 8,
    parameter logic [DEC_W-1:0] WIN_TAG = 8'h01
) (
    input  logic [DEC_W-1:0] tag_i,
    output logic             hit_o
);
    assign hit_o = (tag_i == WIN_TAG);
endmodule

// File: rtl/dram_lane_sel.sv
module dram_lane_sel #(
    parameter int LANES = 4
) (
    input  logic [$clog2(LANES)-1:0] off_i,
    input  logic [1:0]               siz_i,
    input  logic                     rd_i,
    output logic [LANES-1:0]         en_o
);
    localparam int OFF_W = $clog2(LANES);
    localparam int CW    = OFF_W + 2;

    logic [CW-1:0] first;
    logic [CW-1:0] nbytes;
    logic [CW-1:0] stop;

    assign first  = CW'(off_i);
    assign nbytes = (siz_i == 2'b00) ? CW'(4) : CW'(siz_i);
    assign stop   = first + nbytes;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign en_o[i] = rd_i | ((CW'(i) >= first) && (CW'(i) < stop));
    end
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_seq_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int RF_CLKS  = 1,
    parameter int PRE_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             as_n,
    input  logic             rw,
    input  logic             burst_n,
    input  logic             rfq,
    input  logic             ram_hit,
    input  logic [LANES-1:0] lane_en,
    output logic             ras_n,
    output logic             col_sel,
    output logic [LANES-1:0] cas_n,
    output logic             we_n,
    output logic             ref_en,
    output logic             sterm_n,
    output logic [2:0]       phase
);
    localparam int RF_TICKS  = 2 * RF_CLKS;
    localparam int PRE_TICKS = 2 * PRE_CLKS;
    localparam int MAX_T     = (RF_TICKS > PRE_TICKS) ? RF_TICKS : PRE_TICKS;
    localparam int CNT_W     = $clog2(MAX_T + 1);

    typedef struct packed {
        logic             ph;      // 0: next edge is a rising bus edge
        seq_st_e          st;
        logic             ras_n;
        logic             we_n;
        logic             col;
        logic [LANES-1:0] cas_n;
        logic             sterm_n;
        logic             ref_en;
        logic             pend;
        logic             bst;
        logic [CNT_W-1:0] cnt;
        logic [LANES-1:0] lanes;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic      rise, fall;

    assign rise = ~r_q.ph;
    assign fall = r_q.ph;

    always_comb begin
        r_d    = r_q;
        r_d.ph = ~r_q.ph;
        if (rfq) r_d.pend = 1'b1;

        unique case (r_q.st)
            S_IDLE: begin
                if (fall && r_q.pend && (as_n || ram_hit)) begin
                    r_d.st     = S_RF_WAIT;
                    r_d.ref_en = 1'b1;
                end else if (rise && !as_n && ram_hit && !r_q.pend) begin
                    r_d.st    = S_ROW;
                    r_d.ras_n = 1'b0;
                    r_d.we_n  = rw;
                    r_d.lanes = lane_en;
                    r_d.bst   = rw & ~burst_n;
                end
            end
            S_RF_WAIT: begin
                r_d.st    = S_RF_RAS;
                r_d.ras_n = 1'b0;
                r_d.cnt   = CNT_W'(RF_TICKS - 1);
            end
            S_RF_RAS: begin
                if (r_q.cnt == '0) begin
                    r_d.st     = S_PRE;
                    r_d.ras_n  = 1'b1;
                    r_d.ref_en = 1'b0;
                    r_d.cnt    = CNT_W'(PRE_TICKS - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            S_PRE: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = S_IDLE;
                    r_d.pend = rfq;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                if (as_n) begin
                    r_d.st      = S_IDLE;
                    r_d.ras_n   = 1'b1;
                    r_d.we_n    = 1'b1;
                    r_d.col     = 1'b0;
                    r_d.cas_n   = '1;
                    r_d.sterm_n = 1'b1;
                    r_d.bst     = 1'b0;
                end else begin
                    unique case (r_q.st)
                        S_ROW: begin
                            r_d.st  = S_COL;
                            r_d.col = 1'b1;
                        end
                        S_COL: begin
                            r_d.cas_n   = ~r_q.lanes;
                            r_d.sterm_n = 1'b0;
                            r_d.st      = r_q.bst ? S_BURST : S_CAS;
                        end
                        S_CAS: begin
                            if (rise) begin
                                r_d.st    = S_HOLD;
                                r_d.ras_n = 1'b1;
                                r_d.we_n  = 1'b1;
                            end
                        end
                        S_BURST: begin
                            r_d.cas_n = {LANES{r_q.sterm_n}};
                            if (fall) begin
                                if (burst_n) begin
                                    r_d.st      = S_BEND;
                                    r_d.sterm_n = 1'b0;
                                end else begin
                                    r_d.sterm_n = ~r_q.sterm_n;
                                end
                            end
                        end
                        S_BEND: begin
                            if (rise) begin
                                r_d.st    = S_HOLD;
                                r_d.ras_n = 1'b1;
                                r_d.cas_n = '0;
                            end else begin
                                r_d.cas_n = {LANES{r_q.sterm_n}};
                            end
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ph      <= 1'b0;
            r_q.st      <= S_IDLE;
            r_q.ras_n   <= 1'b1;
            r_q.we_n    <= 1'b1;
            r_q.col     <= 1'b0;
            r_q.cas_n   <= '1;
            r_q.sterm_n <= 1'b1;
            r_q.ref_en  <= 1'b0;
            r_q.pend    <= 1'b0;
            r_q.bst     <= 1'b0;
            r_q.cnt     <= '0;
            r_q.lanes   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.st)
            S_IDLE:              phase = PH_IDLE;
            S_RF_WAIT, S_RF_RAS: phase = PH_REF;
            S_PRE:               phase = PH_PRE;
            S_BURST:             phase = PH_BURST;
            default:             phase = PH_ACC;
        endcase
    end

    assign ras_n   = r_q.ras_n;
    assign col_sel = r_q.col;
    assign cas_n   = r_q.cas_n;
    assign we_n    = r_q.we_n;
    assign ref_en  = r_q.ref_en;
    assign sterm_n = r_q.sterm_n;
endmodule

// File: rtl/dram_seq.sv
module dram_seq #(
    parameter int                ADDR_W   = 32,
    parameter int                DEC_W    = 8,
    parameter logic [DEC_W-1:0]  WIN_TAG  = 8'h01,
    parameter int                LANES    = 4,
    parameter int                RF_CLKS  = 1,
    parameter int                PRE_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        siz,
    input  logic              burst_n,
    input  logic              rfq,
    output logic              ras_n,
    output logic              col_sel,
    output logic [LANES-1:0]  cas_n,
    output logic              we_n,
    output logic              ref_en,
    output logic              sterm_n,
    output logic [2:0]        phase
);
    localparam int OFF_W = $clog2(LANES);

    logic             ram_hit;
    logic [LANES-1:0] lane_en;
    logic             addr_unused;

    assign addr_unused = ^addr[ADDR_W-DEC_W-1:OFF_W];

    dram_win_dec #(.DEC_W(DEC_W), .WIN_TAG(WIN_TAG)) u_dec (
        .tag_i (addr[ADDR_W-1 -: DEC_W]),
        .hit_o (ram_hit)
    );

    dram_lane_sel #(.LANES(LANES)) u_lanes (
        .off_i (addr[OFF_W-1:0]),
        .siz_i (siz),
        .rd_i  (rw),
        .en_o  (lane_en)
    );

    dram_seq_fsm #(.LANES(LANES), .RF_CLKS(RF_CLKS), .PRE_CLKS(PRE_CLKS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .as_n    (as_n),
        .rw      (rw),
        .burst_n (burst_n),
        .rfq     (rfq),
        .ram_hit (ram_hit),
        .lane_en (lane_en),
        .ras_n   (ras_n),
        .col_sel (col_sel),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .ref_en  (ref_en),
        .sterm_n (sterm_n),
        .phase   (phase)
    );
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
    parameter int LANES    = 4,
    parameter int PRE_CLKS = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             as_n,
    input logic             ras_n,
    input logic             col_sel,
    input logic [LANES-1:0] cas_n,
    input logic             we_n,
    input logic             ref_en,
    input logic             sterm_n,
    input logic [2:0]       phase
);
    localparam int PRE_TICKS = 2 * PRE_CLKS;
    localparam int GW        = $clog2(PRE_TICKS + 2) + 1;
    localparam logic [GW-1:0] GMAX = '1;

    logic          ref_prev;
    logic          gap_arm;
    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_prev <= 1'b0;
            gap_arm  <= 1'b0;
            gap_cnt  <= '0;
        end else begin
            ref_prev <= ref_en;
            if (ref_prev && !ref_en) begin
                gap_arm <= 1'b1;
                gap_cnt <= GW'(1);
            end else if (!ras_n) begin
                gap_arm <= 1'b0;
            end else if (gap_cnt != GMAX) begin
                gap_cnt <= gap_cnt + GW'(1);
            end
        end
    end

    a_r2_col_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !ref_en && !as_n) |=> col_sel);

    a_r2_cas_after_col: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(col_sel) && !as_n) |=> (cas_n != '1) && !sterm_n);

    a_r3_we_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ras_n);

    a_r6_ref_no_cas: assert property (@(posedge clk) disable iff (!rst_n)
        ref_en |-> (cas_n == '1));

    a_r6_ras_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_en) |=> !ras_n);

    a_r7_precharge_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && gap_arm) |-> (gap_cnt >= GW'(PRE_TICKS)));

    a_r9_burst_holds_row: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd4) |-> !ras_n);

    a_r10_cas_trails_term: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == 3'd4 && phase != 3'd0) |-> (cas_n == {LANES{$past(sterm_n)}}));

    a_r12_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= 3'd4);
endmodule

bind dram_seq dram_seq_chk #(.LANES(LANES), .PRE_CLKS(PRE_CLKS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .as_n    (as_n),
    .ras_n   (ras_n),
    .col_sel (col_sel),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .ref_en  (ref_en),
    .sterm_n (sterm_n),
    .phase   (phase)
);

// File: tb/dram_seq_test.sv
`timescale 1ns/1ps
module dram_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_n = 1'b1;
    logic        rw = 1'b1;
    logic [31:0] addr = '0;
    logic [1:0]  siz = '0;
    logic        burst_n = 1'b1;
    logic        rfq = 1'b0;
    logic        ras_n, col_sel, we_n, ref_en, sterm_n;
    logic [3:0]  cas_n;
    logic [2:0]  phase;

    int n_chk = 0;
    int n_bad = 0;
    int ecount = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dram_seq uut (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .rw(rw), .addr(addr), .siz(siz),
        .burst_n(burst_n), .rfq(rfq), .ras_n(ras_n), .col_sel(col_sel),
        .cas_n(cas_n), .we_n(we_n), .ref_en(ref_en), .sterm_n(sterm_n), .phase(phase)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at tick %0d", tag, act, exp, ecount);
        end
    endtask

    function automatic logic [3:0] exp_cas(input logic [1:0] off, input logic [1:0] sz, input logic rd);
        int n;
        logic [3:0] m;
        if (rd) return 4'h0;
        n = (sz == 2'b00) ? 4 : int'(sz);
        m = '0;
        for (int i = 0; i < 4; i++)
            if (i >= int'(off) && i < int'(off) + n) m[i] = 1'b1;
        return ~m;
    endfunction

    task automatic tick();
        @(posedge clk);
        ecount++;
        @(negedge clk);
    endtask

    task automatic align_rise();
        if (ecount % 2 != 0) tick();
    endtask

    task automatic do_cycle(input logic [31:0] a, input logic [1:0] s, input logic r);
        logic [3:0] ec;
        align_rise();
        addr = a; siz = s; rw = r; burst_n = 1'b1; as_n = 1'b0;
        tick();
        if (a[31:24] != 8'h01) begin
            check("R1 ras outside window", ras_n, 1);
            tick(); tick();
            check("R1 cas outside window", cas_n, 4'hF);
            check("R1 phase outside window", phase, 0);
            as_n = 1'b1;
            tick();
            return;
        end
        ec = exp_cas(a[1:0], s, r);
        check("R2 ras falls", ras_n, 0);
        check("R3 we follows ras", we_n, r);
        tick();
        check("R2 col after ras", col_sel, 1);
        check("R2 cas not yet", cas_n, 4'hF);
        tick();
        check("R5 lane mask", cas_n, ec);
        check("R2 sterm", sterm_n, 0);
        check("R12 access phase", phase, 3);
        tick();
        check("R3 ras held", ras_n, 0);
        tick();
        check("R3 ras release", ras_n, 1);
        check("R3 we release", we_n, 1);
        check("R4 cas held to strobe", cas_n, ec);
        as_n = 1'b1;
        tick();
        check("R4 cas release", cas_n, 4'hF);
        check("R4 sterm release", sterm_n, 1);
        check("R4 col release", col_sel, 0);
        check("R4 phase idle", phase, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h0D1A);
        repeat (3) @(negedge clk);
        check("R13 ras reset", ras_n, 1);
        check("R13 cas reset", cas_n, 4'hF);
        check("R13 we reset", we_n, 1);
        check("R13 sterm reset", sterm_n, 1);
        check("R13 col/ref reset", {col_sel, ref_en}, 0);
        check("R13 phase reset", phase, 0);
        rst_n = 1'b1;

        // directed normal cycles, incl. lane corners
        do_cycle(32'h0100_0000, 2'b00, 1'b1);
        do_cycle(32'h0100_0003, 2'b11, 1'b0);
        do_cycle(32'h0100_0001, 2'b10, 1'b0);
        do_cycle(32'h0100_0002, 2'b00, 1'b0);
        do_cycle(32'h00FF_0008, 2'b00, 1'b1);
        do_cycle(32'h0200_0000, 2'b00, 1'b0);

        // R6/R7: plain refresh from idle
        align_rise();
        rfq = 1'b1; tick(); rfq = 1'b0;
        check("R6 ref waits for falling edge", ref_en, 0);
        tick();
        check("R6 ref_en rises", ref_en, 1);
        check("R12 refresh phase", phase, 1);
        check("R6 ras not yet", ras_n, 1);
        tick();
        check("R6 ras low", ras_n, 0);
        check("R6 no cas", cas_n, 4'hF);
        tick();
        check("R7 ras still low", ras_n, 0);
        tick();
        check("R7 ras high", ras_n, 1);
        check("R7 ref_en off", ref_en, 0);
        check("R12 precharge phase", phase, 2);
        tick(); tick(); tick();
        check("R7 precharge holds", phase, 2);
        tick();
        check("R7 back idle", phase, 0);

        // R8: RAM cycle held off by a pending refresh
        align_rise();
        rfq = 1'b1; tick(); rfq = 1'b0;
        addr = 32'h0100_0010; rw = 1'b1; siz = 2'b00; as_n = 1'b0;
        tick();
        check("R8 refresh first", ref_en, 1);
        check("R8 no access ras", ras_n, 1);
        repeat (7) tick();
        check("R8 idle after precharge", phase, 0);
        check("R8 ras high after precharge", ras_n, 1);
        tick();
        check("R8 still waits for rise", ras_n, 1);
        tick();
        check("R8 held cycle starts", ras_n, 0);
        tick();
        check("R8 col", col_sel, 1);
        tick();
        check("R8 read lanes", cas_n, 4'h0);
        as_n = 1'b1;
        tick();
        check("R4 after held cycle", phase, 0);

        // R6: refresh waits out a non-RAM strobe
        align_rise();
        addr = 32'h00FF_0020; as_n = 1'b0; rfq = 1'b1; tick(); rfq = 1'b0;
        tick(); tick(); tick();
        check("R6 no refresh under foreign strobe", ref_en, 0);
        as_n = 1'b1;
        tick();
        check("R6 still waits for fall", ref_en, 0);
        tick();
        check("R6 refresh after strobe rises", ref_en, 1);
        repeat (8) tick();
        check("R7 idle again", phase, 0);

        // R9-R11: burst read
        align_rise();
        addr = 32'h0100_0040; rw = 1'b1; siz = 2'b00; burst_n = 1'b0; as_n = 1'b0;
        tick();
        check("R9 burst ras", ras_n, 0);
        tick();
        tick();
        check("R9 burst phase", phase, 4);
        check("R10 first beat cas", cas_n, 4'h0);
        check("R10 first beat sterm", sterm_n, 0);
        tick();
        check("R10 sterm toggles on fall", sterm_n, 1);
        check("R10 cas trails", cas_n, 4'h0);
        tick();
        check("R10 cas follows", cas_n, 4'hF);
        check("R9 row held", ras_n, 0);
        tick();
        check("R10 sterm second beat", sterm_n, 0);
        check("R10 cas still high", cas_n, 4'hF);
        tick();
        check("R10 cas second beat", cas_n, 4'h0);
        tick();
        check("R10 sterm off", sterm_n, 1);
        burst_n = 1'b1;
        tick();
        check("R9 row held at rise", ras_n, 0);
        tick();
        check("R11 sterm asserts at end", sterm_n, 0);
        check("R11 access phase", phase, 3);
        tick();
        check("R11 ras released", ras_n, 1);
        check("R11 cas asserted", cas_n, 4'h0);
        as_n = 1'b1;
        tick();
        check("R11 ends normally", {phase, cas_n, sterm_n}, {3'd0, 4'hF, 1'b1});

        // R9: burst request on a write is a normal cycle
        align_rise();
        addr = 32'h0100_0044; rw = 1'b0; siz = 2'b01; burst_n = 1'b0; as_n = 1'b0;
        tick(); tick(); tick();
        check("R9 write not burst", phase, 3);
        tick(); tick();
        check("R9 write ras releases", ras_n, 1);
        as_n = 1'b1; burst_n = 1'b1;
        tick();

        // random normal cycles
        for (int k = 0; k < 40; k++) begin
            logic [31:0] rv;
            logic [7:0]  hi;
            rv = $urandom();
            case (rv[31:30])
                2'd0: hi = 8'h00;
                2'd1: hi = 8'h02;
                default: hi = 8'h01;
            endcase
            do_cycle({hi, rv[23:0]}, rv[25:24], rv[26]);
            repeat (int'(rv[28:27])) tick();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule